// File: doc/BRIEF.md
# RC5 Infrared Frame Receiver

This block turns a demodulated infrared line into one 14-bit RC5 word. The line is already in true polarity and sits low when idle. It is clocked by the system clock, and all of its timing comes from a 32-ticks-per-bit enable pulse. While the receiver is idle, a rising edge on the line marks the middle of the first start bit. From that edge a single free-running tick counter sets the sample instants. The receiver takes one sample three quarters of the way into every bit period, which reads the Manchester level of the bit's second half.

After fourteen samples the shift path is frozen. The counter keeps running until a guard interval of 32 bit times has passed since the start edge. At that point the receiver pulses its valid output and goes back to idle to wait for the next frame. The captured word is shown whole and also split into its toggle, address and command fields. A host can latch these fields on the valid pulse to drive an appliance function.

Top module: `rc5_frame_rx`

## Requirements
- R1: The line input passes through a two-stage synchronizer. A rising edge starts a frame only while the receiver is idle. Edges inside a running frame never restart it, so the valid pulse keeps its fixed timing.
- R2: Each bit is read once, at 24 ticks into its 32-tick bit period, which is 8, 40, 72 … ticks after the start edge. A low-then-high bit reads as 1 and a high-then-low bit reads as 0.
- R3: Exactly 14 bits are captured per frame. They enter `frame_word` most significant first, so the first bit received ends in bit 13.
- R4: Once the 14th bit is captured, further activity on the line during the guard interval leaves `frame_word` unchanged.
- R5: A start edge clears `frame_word` to zero before the first sample. Until that start edge, the previous word stays on the output.
- R6: `frame_valid` goes high for exactly one clock, 1024 ticks (32 bit times) after the start edge, give or take the synchronizer latency. The receiver is idle afterwards.
- R7: `toggle_bit` is `frame_word[11]`, `address` is `frame_word[10:6]` and `command` is `frame_word[5:0]`.
- R8: A synchronous reset clears `frame_word` and `frame_valid` and returns the receiver to idle. A reset in the middle of a frame abandons that frame without producing a valid pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| tick_en | input | 1 | Time-base enable, 32 pulses per bit period |
| ir_in | input | 1 | Demodulated line, true polarity, idle low |
| frame_word | output | 14 | Captured frame, first bit received in bit 13 |
| toggle_bit | output | 1 | Toggle field of the captured frame |
| address | output | 5 | Address field of the captured frame |
| command | output | 6 | Command field of the captured frame |
| frame_valid | output | 1 | One-clock pulse marking the end of the guard interval |

## Verification
The hardest situation to reach is line activity inside a running frame. That includes edges between bits and toggling after the 14th sample. Such activity must neither restart the counter nor reach the frozen word. To create it, every other vector in the table is followed by a burst of fast toggling during the guard interval. The bench then checks that the valid pulse still arrives 1024 ticks after the first edge and that the word matches the vector. A directed test applies reset part-way through a frame and confirms that no valid pulse follows.

// File: rtl/rc5_rx_pkg.sv
package rc5_rx_pkg;

  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_RUN  = 1'b1
  } rx_state_e;

  // Sample instant: a quarter bit after each counter bit boundary.
  // The start edge lies half a bit into bit 0, so this is 3/4 of each bit.
  function automatic logic at_sample_point(input int unsigned cnt,
                                           input int unsigned tpb);
    return (cnt % tpb) == (tpb / 4);
  endfunction

  function automatic logic field_toggle(input logic [11:0] low);
    return low[11];
  endfunction

  function automatic logic [4:0] field_address(input logic [11:0] low);
    return low[10:6];
  endfunction

  function automatic logic [5:0] field_command(input logic [11:0] low);
    return low[5:0];
  endfunction

endpackage

// File: rtl/rc5_in_sync.sv
module rc5_in_sync (
  input  logic clk,
  input  logic rst,
  input  logic din,
  output logic level,
  output logic rise
);
  logic [2:0] stg;

  always_ff @(posedge clk) begin
    if (rst) stg <= '0;
    else     stg <= {stg[1:0], din};
  end

  assign level = stg[1];
  assign rise  = stg[1] & ~stg[2];
endmodule

// File: rtl/rc5_frame_timer.sv
module rc5_frame_timer
  import rc5_rx_pkg::*;
#(
  parameter int unsigned TICKS_PER_BIT = 32,
  parameter int unsigned NUM_BITS      = 14,
  parameter int unsigned GUARD_BITS    = 32,
  localparam int unsigned GUARD_TICKS  = GUARD_BITS * TICKS_PER_BIT,
  localparam int unsigned CW           = $clog2(GUARD_TICKS + 1),
  localparam int unsigned BW           = $clog2(NUM_BITS + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          tick_en,
  input  logic          start_req,
  output logic          busy,
  output logic          start_pulse,
  output logic          sample_stb,
  output logic          done_stb,
  output logic [BW-1:0] bit_cnt
);
  rx_state_e     state;
  logic [CW-1:0] cnt;

  assign busy        = (state == ST_RUN);
  assign start_pulse = (state == ST_IDLE) && start_req;
  assign sample_stb  = busy && tick_en && at_sample_point(32'(cnt), TICKS_PER_BIT)
                       && (bit_cnt < BW'(NUM_BITS));
  assign done_stb    = busy && tick_en && (cnt == CW'(GUARD_TICKS - 1));

  always_ff @(posedge clk) begin
    if (rst) begin
      state   <= ST_IDLE;
      cnt     <= '0;
      bit_cnt <= '0;
    end else if (start_pulse) begin
      state   <= ST_RUN;
      cnt     <= '0;
      bit_cnt <= '0;
    end else if (busy && tick_en) begin
      if (done_stb) begin
        state <= ST_IDLE;
        cnt   <= '0;
      end else begin
        cnt <= cnt + 1'b1;
      end
      if (sample_stb) bit_cnt <= bit_cnt + 1'b1;
    end
  end
endmodule

// File: rtl/rc5_shift_capture.sv
module rc5_shift_capture #(
  parameter int unsigned NUM_BITS = 14
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                clear,
  input  logic                shift,
  input  logic                din,
  output logic [NUM_BITS-1:0] word
);
  always_ff @(posedge clk) begin
    if (rst || clear) word <= '0;
    else if (shift)   word <= {word[NUM_BITS-2:0], din};
  end
endmodule

// File: rtl/rc5_frame_rx.sv
module rc5_frame_rx
  import rc5_rx_pkg::*;
#(
  parameter int unsigned TICKS_PER_BIT = 32,
  parameter int unsigned NUM_BITS      = 14,
  parameter int unsigned GUARD_BITS    = 32,
  localparam int unsigned BW           = $clog2(NUM_BITS + 1)
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                tick_en,
  input  logic                ir_in,
  output logic [NUM_BITS-1:0] frame_word,
  output logic                toggle_bit,
  output logic [4:0]          address,
  output logic [5:0]          command,
  output logic                frame_valid
);
  // Named internal events, observed by the bound checker.
  logic          line_lvl;
  logic          line_rise;
  logic          busy;
  logic          start_pulse;
  logic          sample_stb;
  logic          done_stb;
  logic [BW-1:0] bit_cnt;

  rc5_in_sync u_sync (
    .clk   (clk),
    .rst   (rst),
    .din   (ir_in),
    .level (line_lvl),
    .rise  (line_rise)
  );

  rc5_frame_timer #(
    .TICKS_PER_BIT (TICKS_PER_BIT),
    .NUM_BITS      (NUM_BITS),
    .GUARD_BITS    (GUARD_BITS)
  ) u_timer (
    .clk         (clk),
    .rst         (rst),
    .tick_en     (tick_en),
    .start_req   (line_rise),
    .busy        (busy),
    .start_pulse (start_pulse),
    .sample_stb  (sample_stb),
    .done_stb    (done_stb),
    .bit_cnt     (bit_cnt)
  );

  rc5_shift_capture #(
    .NUM_BITS (NUM_BITS)
  ) u_cap (
    .clk   (clk),
    .rst   (rst),
    .clear (start_pulse),
    .shift (sample_stb),
    .din   (line_lvl),
    .word  (frame_word)
  );

  always_ff @(posedge clk) begin
    if (rst) frame_valid <= 1'b0;
    else     frame_valid <= done_stb;
  end

  assign toggle_bit = field_toggle(frame_word[11:0]);
  assign address    = field_address(frame_word[11:0]);
  assign command    = field_command(frame_word[11:0]);
endmodule

// File: rtl/rc5_rx_chk.sv
module rc5_rx_chk #(
  parameter int unsigned NUM_BITS = 14,
  localparam int unsigned BW      = $clog2(NUM_BITS + 1)
) (
  input logic                clk,
  input logic                rst,
  input logic                tick_en,
  input logic                busy,
  input logic                start_pulse,
  input logic                sample_stb,
  input logic                done_stb,
  input logic [BW-1:0]       bit_cnt,
  input logic [NUM_BITS-1:0] frame_word,
  input logic                frame_valid
);
  // R1
  start_only_idle_chk: assert property (@(posedge clk) disable iff (rst)
    start_pulse |-> !busy);

  // R2
  sample_in_frame_chk: assert property (@(posedge clk) disable iff (rst)
    sample_stb |-> (busy && tick_en));

  // R3
  count_bound_chk: assert property (@(posedge clk) disable iff (rst)
    bit_cnt <= BW'(NUM_BITS));

  // R4
  full_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (busy && bit_cnt == BW'(NUM_BITS)) |=> $stable(frame_word));

  // R5
  start_clear_chk: assert property (@(posedge clk) disable iff (rst)
    start_pulse |=> (frame_word == '0));

  // R5
  idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!busy && !start_pulse) |=> $stable(frame_word));

  // R6
  valid_single_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    frame_valid |=> !frame_valid);

  // R6
  valid_after_done_chk: assert property (@(posedge clk) disable iff (rst)
    frame_valid |-> $past(done_stb));
endmodule

bind rc5_frame_rx rc5_rx_chk #(.NUM_BITS(NUM_BITS)) u_chk (
  .clk         (clk),
  .rst         (rst),
  .tick_en     (tick_en),
  .busy        (busy),
  .start_pulse (start_pulse),
  .sample_stb  (sample_stb),
  .done_stb    (done_stb),
  .bit_cnt     (bit_cnt),
  .frame_word  (frame_word),
  .frame_valid (frame_valid)
);

// File: tb/sim_rc5_frame_rx.sv
`timescale 1ns/1ps
module sim_rc5_frame_rx;
  localparam int HALF_CLKS = 64;   // 16 ticks, 4 clocks per tick
  localparam int GUARD_CLK = 4096; // 1024 ticks

  localparam logic [13:0] VEC [8] = '{
    14'h3000, 14'h3FFF, 14'h3AAA, 14'h3555,
    14'h394C, 14'h3040, 14'h3001, 14'h3823
  };

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        ir_in = 1'b0;
  logic        tick_en;
  logic [1:0]  tdiv = 2'd0;
  logic [13:0] frame_word;
  logic        toggle_bit;
  logic [4:0]  address;
  logic [5:0]  command;
  logic        frame_valid;
  int unsigned cyc = 0;
  int          n_run = 0;
  int          n_fail = 0;

  always #2.5 clk = ~clk;
  always @(posedge clk) begin
    tdiv <= tdiv + 2'd1;
    cyc  <= cyc + 1;
  end
  assign tick_en = (tdiv == 2'd3);

  rc5_frame_rx u0 (
    .clk (clk), .rst (rst), .tick_en (tick_en), .ir_in (ir_in),
    .frame_word (frame_word), .toggle_bit (toggle_bit), .address (address),
    .command (command), .frame_valid (frame_valid)
  );

  task automatic check(input string req, input logic [31:0] act,
                       input logic [31:0] exp, input string what);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: got %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic check_range(input string req, input int unsigned act,
                             input int unsigned lo, input int unsigned hi,
                             input string what);
    n_run++;
    if (act < lo || act > hi) begin
      n_fail++;
      $display("FAIL %s %s: got %0d expected %0d..%0d", req, what, act, lo, hi);
    end
  endtask

  // Manchester: bit 1 = low then high, bit 0 = high then low.
  task automatic send_frame(input logic [13:0] w, input logic [13:0] old_w,
                            input bit junk, output int unsigned t0);
    t0 = 0;
    for (int i = 13; i >= 0; i--) begin
      ir_in = ~w[i];
      repeat (HALF_CLKS) @(negedge clk);
      if (i == 13) begin
        check("R5", 32'(frame_word), 32'(old_w), "old word held until start");
        ir_in = w[i];
        t0 = cyc;
        repeat (16) @(negedge clk);
        check("R5", 32'(frame_word), 32'h0, "word cleared at start");
        repeat (HALF_CLKS - 16) @(negedge clk);
      end else begin
        ir_in = w[i];
        repeat (HALF_CLKS) @(negedge clk);
      end
    end
    ir_in = 1'b0;
    if (junk) begin
      for (int k = 0; k < 40; k++) begin
        ir_in = ~ir_in;
        repeat (10) @(negedge clk);
      end
      ir_in = 1'b0;
    end
  endtask

  task automatic wait_valid(output bit seen);
    int w = 0;
    while (!frame_valid && w < 6000) begin
      @(negedge clk);
      w++;
    end
    seen = frame_valid;
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    n_fail++;
    $display("FAIL R6 watchdog: got timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    int unsigned t0;
    bit seen;
    logic [13:0] prev;

    repeat (5) @(negedge clk);
    // R8 reset state
    check("R8", 32'(frame_word), 32'h0, "word after reset");
    check("R8", 32'(frame_valid), 32'h0, "valid after reset");
    rst = 1'b0;
    repeat (20) @(negedge clk);

    prev = 14'h0;
    for (int v = 0; v < 8; v++) begin
      send_frame(VEC[v], prev, v[0], t0);
      wait_valid(seen);
      check("R6", 32'(seen), 32'h1, "valid pulse seen");
      // R1: edges inside the frame (and junk) never restart the timer
      check_range("R1", cyc - t0, GUARD_CLK - 6, GUARD_CLK + 14, "valid delay after start edge");
      // R2/R3/R4: word matches the sent bits, MSB first, despite guard junk
      check(v[0] ? "R4" : "R3", 32'(frame_word), 32'(VEC[v]), "captured word");
      check("R2", 32'(frame_word[13:12]), 32'h3, "start bits read as 1");
      // R7 fields
      check("R7", 32'(toggle_bit), 32'(VEC[v][11]), "toggle field");
      check("R7", 32'(address), 32'(VEC[v][10:6]), "address field");
      check("R7", 32'(command), 32'(VEC[v][5:0]), "command field");
      @(negedge clk);
      check("R6", 32'(frame_valid), 32'h0, "valid lasts one clock");
      repeat (200) @(negedge clk);
      check("R5", 32'(frame_word), 32'(VEC[v]), "word held while idle");
      prev = VEC[v];
    end

    // R8: reset in the middle of a frame abandons it
    ir_in = 1'b0;
    repeat (HALF_CLKS) @(negedge clk);
    ir_in = 1'b1;
    repeat (6 * 2 * HALF_CLKS) @(negedge clk);
    rst = 1'b1;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    ir_in = 1'b0;
    @(negedge clk);
    check("R8", 32'(frame_word), 32'h0, "word cleared by mid-frame reset");
    check("R8", 32'(frame_valid), 32'h0, "valid low after reset");
    wait_valid(seen);
    check("R8", 32'(seen), 32'h0, "no valid after abandoned frame");

    send_frame(14'h394C, 14'h0, 1'b0, t0);
    wait_valid(seen);
    check("R8", 32'(frame_word), 32'h394C, "decode after reset recovery");
    check_range("R6", cyc - t0, GUARD_CLK - 6, GUARD_CLK + 14, "valid delay after recovery");

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule